// File: doc/BRIEF.md
# Logic Self-Test Run Sequencer

This block drives one logic self-test run across a pair of redundant processor cores. Software sets up the run through a small register bus. It writes a test interval count, a timeout preload, a clock divide value and a core-select field, then writes a start key. While the run is active the block counts divided clock enables. It groups them into intervals, and groups the intervals into segments that follow one another. At the end of every interval it samples one compare-fail flag per core. A timeout counter runs alongside the intervals.

When the run ends, either because every interval has finished or because the timeout ran out, the block sets a done flag. It also sets a fail flag and a three-bit cause field, and raises a one-cycle core reset request. It then disarms itself until software writes the key again. The scan and signature hardware sits outside the block. Its per-core verdict arrives on the compare-fail input.

Register map (word address on `bus_addr`): 0 = interval count in bits [31:16]; 1 = start key in bits [3:0] and core select in bits [9:8]; 2 = 32-bit timeout preload; 3 = status, with done in bit 0 and fail in bit 1; 4 = cause, with timeout in bit 0, core 1 in bit 1 and core 2 in bit 2; 5 = divide value in bits [2:0]. Core 1 is `cmp_fail[0]` and core 2 is `cmp_fail[1]`. With the default parameters an interval is 4 clock enables and a segment is 8 intervals.

Top module: `lbist_run_ctrl`

## Requirements
- R1: After reset every register reads 0, `run_busy`, `core_mask` and `core_rst_req` are 0, and no run is active.
- R2: Writing 0xA to bits [3:0] of address 1 while idle starts a run on the next clock edge. Any other value in that field leaves the block idle.
- R3: A run with interval count N (address 0, bits [31:16]) lasts N × 4 clock enables after the start edge. A count of 0 ends the run at the first clock enable with no failure.
- R4: Segments run in order. `seg_id` equals the number of completed intervals divided by 8, held at the last segment.
- R5: Core select (address 1, bits [9:8]) applies to segment 0 only. A value of 1 tests core 1 alone, 2 tests core 2 alone, and 0 or 3 tests both. Later segments test both cores. `core_mask` shows the cores under test and is 0 when idle.
- R6: At each interval end, a set compare-fail flag on a core under test sets that core's cause bit (bit 1 for core 1, bit 2 for core 2). The run still goes on to its full length.
- R7: The timeout counter loads the preload (0xFFFFFFFF accepted) at start and counts down once per clock enable. When it reaches zero before the last interval ends, the run stops and cause bit 0 is set. If the last interval ends on that same enable, the run completes normally.
- R8: At run end the done bit is set, and the fail bit is set exactly when any cause bit is set.
- R9: `core_rst_req` pulses for exactly one cycle, in the cycle the done bit becomes visible. At the same time the key field is cleared to 0 and the core select is kept.
- R10: Writing 1 to a status or cause bit clears it. Starting a run clears done, fail and cause before the first interval.
- R11: The clock enable fires once every (divide value + 1) clocks.
- R12: While a run is active, writes to addresses 0, 1, 2 and 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmp_fail | input | 2 | Per-core signature mismatch flag |
| run_busy | output | 1 | A run is in progress |
| seg_id | output | SEG_W | Current segment index |
| core_mask | output | 2 | Cores under test in the current segment |
| core_rst_req | output | 1 | One-cycle core reset request at run end |

## Verification
The checks assume that `cmp_fail` is stable around each interval end, and that software never changes configuration in the middle of a run. The block enforces the second point by ignoring such writes. They also assume at most one bus write per cycle, to an address inside the map. The stimulus holds `cmp_fail` constant for the whole of each run. It drives every bus access half a cycle away from the sampling edge, so that reset pulses, segment steps and mask changes can be related to one another cycle by cycle.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
    localparam int ADDR_W  = 3;
    localparam int NCORE   = 2;
    localparam int CAUSE_W = 3;
    localparam int CDIV_W  = 3;
    localparam int CB_TMO  = 0;
    localparam int CB_CORE = 1;   // core k reports on bit CB_CORE+k

    localparam logic [3:0] RUN_KEY = 4'hA;

    localparam logic [ADDR_W-1:0] A_CTRL0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_TMO   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAUSE = 3'd4;
    localparam logic [ADDR_W-1:0] A_CDIV  = 3'd5;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;

    typedef struct packed {
        logic [15:0]       n_int;
        logic [1:0]        core_sel;
        logic [3:0]        key;
        logic [31:0]       tmo_pre;
        logic [CDIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/lbist_clk_en.sv
module lbist_clk_en #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             ce
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ce    = (cnt_q >= div_sel);
        cnt_d = ce ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
    import lbist_pkg::*;
#(
    parameter int INTERVAL_TICKS = 4,
    parameter int SEG_LEN_LOG2   = 3,
    parameter int NUM_SEGS       = 4,
    parameter int SEG_W          = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_t               cfg,
    input  logic               ce,
    input  logic [NCORE-1:0]   cmp_fail,
    output logic               busy,
    output logic               start,
    output logic               fin,
    output logic [CAUSE_W-1:0] cause_set,
    output logic [SEG_W-1:0]   seg_id,
    output logic [NCORE-1:0]   core_mask,
    output logic               rst_req
);
    localparam int TICK_W = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;

    typedef struct packed {
        run_state_e        st;
        logic [31:0]       tmo;
        logic [TICK_W-1:0] tick;
        logic [15:0]       icnt;
        logic              rst_req;
    } seq_t;

    seq_t             d, q;
    logic [NCORE-1:0] sel_mask;
    logic [15:0]      seg_raw;
    logic             iend;
    logic             all_done;

    always_comb begin
        unique case (cfg.core_sel)
            2'd1:    sel_mask = 2'b01;
            2'd2:    sel_mask = 2'b10;
            default: sel_mask = 2'b11;
        endcase
        seg_raw   = q.icnt >> SEG_LEN_LOG2;
        seg_id    = (seg_raw > 16'(NUM_SEGS - 1)) ? SEG_W'(NUM_SEGS - 1) : seg_raw[SEG_W-1:0];
        busy      = (q.st == ST_RUN);
        core_mask = !busy ? '0 : ((seg_id == '0) ? sel_mask : '1);
        start     = (q.st == ST_IDLE) && (cfg.key == RUN_KEY);
        iend      = (q.tick == TICK_W'(INTERVAL_TICKS - 1));
        all_done  = (cfg.n_int == '0) ||
                    (iend && (({1'b0, q.icnt} + 17'd1) == {1'b0, cfg.n_int}));
        rst_req   = q.rst_req;

        d         = q;
        d.rst_req = 1'b0;
        fin       = 1'b0;
        cause_set = '0;

        if (start) begin
            d.st   = ST_RUN;
            d.tmo  = cfg.tmo_pre;
            d.tick = '0;
            d.icnt = '0;
        end else if (busy && ce) begin
            d.tmo  = (q.tmo != '0) ? q.tmo - 32'd1 : '0;
            d.tick = iend ? '0 : q.tick + 1'b1;
            if (iend && (cfg.n_int != '0)) begin
                for (int k = 0; k < NCORE; k++) begin
                    cause_set[CB_CORE + k] = core_mask[k] & cmp_fail[k];
                end
                d.icnt = q.icnt + 16'd1;
            end
            if (all_done) begin
                fin = 1'b1;
            end else if (q.tmo <= 32'd1) begin
                fin               = 1'b1;
                cause_set[CB_TMO] = 1'b1;
            end
            if (fin) begin
                d.st      = ST_IDLE;
                d.rst_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, tmo: '0, tick: '0, icnt: '0, rst_req: 1'b0};
        else        q <= d;
    end
endmodule

// File: rtl/lbist_regs.sv
module lbist_regs
    import lbist_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic               busy,
    input  logic               start,
    input  logic               fin,
    input  logic [CAUSE_W-1:0] cause_set,
    output cfg_t               cfg,
    output logic               stat_done
);
    typedef struct packed {
        cfg_t               cfg;
        logic               done;
        logic               fail;
        logic [CAUSE_W-1:0] cause;
    } reg_t;

    reg_t d, q;

    always_comb begin
        d = q;
        if (wr && !busy) begin
            unique case (addr)
                A_CTRL0: d.cfg.n_int = wdata[31:16];
                A_CTRL1: begin
                    d.cfg.key      = wdata[3:0];
                    d.cfg.core_sel = wdata[9:8];
                end
                A_TMO:   d.cfg.tmo_pre = wdata;
                A_CDIV:  d.cfg.div     = wdata[CDIV_W-1:0];
                default: ;
            endcase
        end
        if (wr && (addr == A_STAT)) begin
            d.done = q.done & ~wdata[0];
            d.fail = q.fail & ~wdata[1];
        end
        if (wr && (addr == A_CAUSE)) d.cause = q.cause & ~wdata[CAUSE_W-1:0];
        d.cause = d.cause | cause_set;
        if (start) begin
            d.done  = 1'b0;
            d.fail  = 1'b0;
            d.cause = '0;
        end
        if (fin) begin
            d.done    = 1'b1;
            d.fail    = |d.cause;
            d.cfg.key = '0;
        end

        unique case (addr)
            A_CTRL0: rdata = {q.cfg.n_int, 16'h0};
            A_CTRL1: rdata = {22'h0, q.cfg.core_sel, 4'h0, q.cfg.key};
            A_TMO:   rdata = q.cfg.tmo_pre;
            A_STAT:  rdata = {30'h0, q.fail, q.done};
            A_CAUSE: rdata = {{(32-CAUSE_W){1'b0}}, q.cause};
            A_CDIV:  rdata = {{(32-CDIV_W){1'b0}}, q.cfg.div};
            default: rdata = '0;
        endcase
        cfg       = q.cfg;
        stat_done = q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/lbist_run_ctrl.sv
module lbist_run_ctrl
    import lbist_pkg::*;
#(
    parameter int INTERVAL_TICKS = 4,
    parameter int SEG_LEN_LOG2   = 3,
    parameter int NUM_SEGS       = 4,
    parameter int SEG_W          = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCORE-1:0]  cmp_fail,
    output logic              run_busy,
    output logic [SEG_W-1:0]  seg_id,
    output logic [NCORE-1:0]  core_mask,
    output logic              core_rst_req
);
    cfg_t               cfg;
    logic               clk_en;
    logic               start;
    logic               fin;
    logic [CAUSE_W-1:0] cause_set;
    logic               stat_done;

    lbist_clk_en #(.DIV_W(CDIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (cfg.div),
        .ce      (clk_en)
    );

    lbist_seq #(
        .INTERVAL_TICKS (INTERVAL_TICKS),
        .SEG_LEN_LOG2   (SEG_LEN_LOG2),
        .NUM_SEGS       (NUM_SEGS),
        .SEG_W          (SEG_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .ce        (clk_en),
        .cmp_fail  (cmp_fail),
        .busy      (run_busy),
        .start     (start),
        .fin       (fin),
        .cause_set (cause_set),
        .seg_id    (seg_id),
        .core_mask (core_mask),
        .rst_req   (core_rst_req)
    );

    lbist_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .busy      (run_busy),
        .start     (start),
        .fin       (fin),
        .cause_set (cause_set),
        .cfg       (cfg),
        .stat_done (stat_done)
    );
endmodule

// File: rtl/lbist_run_ctrl_chk.sv
module lbist_run_ctrl_chk #(
    parameter int SEG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_busy,
    input logic             core_rst_req,
    input logic             stat_done,
    input logic             ce,
    input logic [1:0]       core_mask,
    input logic [SEG_W-1:0] seg_id
);
    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req |=> !core_rst_req);

    // R9
    rst_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_busy) |-> core_rst_req);

    // R8
    done_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_done) |-> core_rst_req);

    // R5
    idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_busy |-> (core_mask == 2'b00));

    // R5
    busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_busy |-> (core_mask != 2'b00));

    // R4
    seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_busy && $past(run_busy)) |-> (seg_id >= $past(seg_id)));

    // R11
    seg_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_busy && $past(run_busy) && !$past(ce)) |-> $stable(seg_id));
endmodule

bind lbist_run_ctrl lbist_run_ctrl_chk #(.SEG_W(SEG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_busy     (run_busy),
    .core_rst_req (core_rst_req),
    .stat_done    (stat_done),
    .ce           (clk_en),
    .core_mask    (core_mask),
    .seg_id       (seg_id)
);

// File: tb/lbist_run_ctrl_test.sv
module lbist_run_ctrl_test;
    import lbist_pkg::*;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cmp_fail = '0;
    logic        run_busy;
    logic [1:0]  seg_id;
    logic [1:0]  core_mask;
    logic        core_rst_req;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    lbist_run_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_fail(cmp_fail),
        .run_busy(run_busy), .seg_id(seg_id), .core_mask(core_mask),
        .core_rst_req(core_rst_req)
    );

    typedef struct packed {
        logic [15:0] n;
        logic [1:0]  sel;
        logic [1:0]  cf;
        logic [31:0] pre;
        logic [15:0] cyc;
        logic [2:0]  cause;
    } vec_t;

    // cycles counted from the key write edge to the first sample with done set
    localparam vec_t VECS [9] = '{
        '{16'd4,  2'd0, 2'b00, 32'hFFFF_FFFF, 16'd17, 3'b000},
        '{16'd4,  2'd1, 2'b10, 32'hFFFF_FFFF, 16'd17, 3'b000},
        '{16'd4,  2'd0, 2'b10, 32'hFFFF_FFFF, 16'd17, 3'b100},
        '{16'd4,  2'd2, 2'b01, 32'hFFFF_FFFF, 16'd17, 3'b000},
        '{16'd12, 2'd1, 2'b10, 32'hFFFF_FFFF, 16'd49, 3'b100},
        '{16'd40, 2'd0, 2'b00, 32'd5,         16'd6,  3'b001},
        '{16'd3,  2'd0, 2'b11, 32'd12,        16'd13, 3'b110},
        '{16'd0,  2'd0, 2'b11, 32'hFFFF_FFFF, 16'd2,  3'b000},
        '{16'd4,  2'd2, 2'b11, 32'hFFFF_FFFF, 16'd17, 3'b100}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic start_run(input logic [15:0] n, input logic [1:0] sel,
                             input logic [1:0] cf, input logic [31:0] pre);
        wr(A_CTRL0, {n, 16'h0});
        wr(A_TMO, pre);
        cmp_fail = cf;
        wr(A_CTRL1, {22'h0, sel, 4'h0, 4'hA});
    endtask

    task automatic wait_done(input int c0, output int cyc, output logic [31:0] st,
                             output logic [31:0] cs, output logic rst_ok);
        cyc = c0; st = '0;
        while (cyc < 4000) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            rd(A_STAT, st);
            if (st[0]) break;
        end
        rst_ok = core_rst_req;
        @(posedge clk); @(negedge clk);
        rst_ok = rst_ok & !core_rst_req;
        rd(A_CAUSE, cs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int          cyc;
        logic [31:0] st, cs, v;
        logic        rok;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk(v == 32'h0, "R1 register reset value", v, 32'h0);
        end
        chk(!run_busy && !core_rst_req && core_mask == 2'b00, "R1 idle outputs",
            {29'h0, run_busy, core_mask}, 32'h0);

        // Table: R3 R5 R6 R7 R8 R9
        for (int i = 0; i < 9; i++) begin
            start_run(VECS[i].n, VECS[i].sel, VECS[i].cf, VECS[i].pre);
            wait_done(0, cyc, st, cs, rok);
            chk(cyc == int'(VECS[i].cyc), "R3/R7 run length", cyc, VECS[i].cyc);
            chk(cs[2:0] == VECS[i].cause, "R6/R7 cause bits", cs, {29'h0, VECS[i].cause});
            chk(st[1] == |VECS[i].cause, "R8 fail bit", st, {30'h0, |VECS[i].cause, 1'b1});
            chk(rok, "R9 one-cycle reset request", {31'h0, rok}, 32'h1);
        end

        // R7: maximum preload accepted
        rd(A_TMO, v);
        chk(v == 32'hFFFF_FFFF, "R7 preload readback", v, 32'hFFFF_FFFF);

        // R10: write-one-to-clear (state: done=1 fail=1 cause=100)
        wr(A_STAT, 32'h1); @(negedge clk); rd(A_STAT, v);
        chk(v == 32'h2, "R10 clear done only", v, 32'h2);
        wr(A_CAUSE, 32'h4); @(negedge clk); rd(A_CAUSE, v);
        chk(v == 32'h0, "R10 clear cause", v, 32'h0);
        wr(A_STAT, 32'h2); @(negedge clk); rd(A_STAT, v);
        chk(v == 32'h0, "R10 clear fail", v, 32'h0);

        // R10: start clears a previous failure before the first interval
        start_run(16'd4, 2'd0, 2'b11, 32'hFFFF_FFFF);
        wait_done(0, cyc, st, cs, rok);
        chk(st[1:0] == 2'b11, "R10 setup failing run", st, 32'h3);
        start_run(16'd4, 2'd0, 2'b00, 32'hFFFF_FFFF);
        @(posedge clk); @(negedge clk);
        rd(A_STAT, v);
        chk(v == 32'h0, "R10 start clears status", v, 32'h0);
        rd(A_CAUSE, v);
        chk(v == 32'h0, "R10 start clears cause", v, 32'h0);
        wait_done(1, cyc, st, cs, rok);
        chk(cyc == 17 && st[1:0] == 2'b01, "R10 clean run after clear", cyc, 32'd17);

        // R4 R5 R12: segment stepping and write protection during a run
        start_run(16'd40, 2'd1, 2'b00, 32'hFFFF_FFFF);
        repeat (2) @(posedge clk); @(negedge clk);
        chk(run_busy, "R2 key starts run", {31'h0, run_busy}, 32'h1);
        chk(core_mask == 2'b01 && seg_id == 2'd0, "R5 segment 0 core 1 only",
            {30'h0, core_mask}, 32'h1);
        repeat (30) @(posedge clk); @(negedge clk);
        chk(seg_id == 2'd0, "R4 still segment 0 at cycle 32", {30'h0, seg_id}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk(seg_id == 2'd1, "R4 segment 1 at cycle 33", {30'h0, seg_id}, 32'h1);
        chk(core_mask == 2'b11, "R5 later segment tests both", {30'h0, core_mask}, 32'h3);
        wr(A_CTRL0, 32'h0007_0000); @(negedge clk); rd(A_CTRL0, v);
        chk(v == 32'h0028_0000, "R12 count write ignored", v, 32'h0028_0000);
        wr(A_CTRL1, 32'h0000_020A); @(negedge clk); rd(A_CTRL1, v);
        chk(v == 32'h0000_010A, "R12 control write ignored", v, 32'h0000_010A);
        repeat (60) @(posedge clk); @(negedge clk);
        chk(seg_id == 2'd3, "R4 last segment held", {30'h0, seg_id}, 32'h3);
        wait_done(0, cyc, st, cs, rok);
        chk(st[1:0] == 2'b01, "R3 long run passes", st, 32'h1);
        rd(A_CTRL1, v);
        chk(v == 32'h0000_0100, "R9 key cleared select kept", v, 32'h0000_0100);

        // R11: divide by three
        wr(A_CDIV, 32'h2); @(negedge clk); rd(A_CDIV, v);
        chk(v == 32'h2, "R11 divide readback", v, 32'h2);
        start_run(16'd2, 2'd0, 2'b00, 32'hFFFF_FFFF);
        wait_done(0, cyc, st, cs, rok);
        chk(cyc >= 23 && cyc <= 25, "R11 divided run length", cyc, 32'd24);
        wr(A_CDIV, 32'h0);

        // R2: wrong key leaves the block idle
        wr(A_CTRL1, 32'h0000_0005);
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); @(negedge clk);
            chk(!run_busy, "R2 wrong key no start", {31'h0, run_busy}, 32'h0);
        end
        rd(A_STAT, v);
        chk(v == 32'h1, "R2 status untouched", v, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule